// File: doc/BRIEF.md
# Configuration Bus Device Enumerator

This block walks every device and function slot of one configuration bus and reports what it finds. It is started by a one-cycle pulse that captures the bus number. It then issues single-word configuration reads through a request/response port, with one read outstanding at a time. The device number is the outer loop and the function number the inner loop. For every slot it first reads the identity word. An all-ones return marks an empty slot, which is skipped without a record. For an occupied slot the block also reads the class word and the header word. It then offers one record on a valid/ready output and waits until that record is taken. After the final slot has been handled it raises a done flag and stays idle until the next start.

The block is built around one state machine with these states:
- ST_IDLE waits for start and moves to ST_ID_REQ.
- ST_ID_REQ issues the identity read and moves to ST_ID_WAIT when the request is accepted.
- ST_ID_WAIT waits for the response. On an all-ones word it moves to ST_ID_REQ, or to ST_DONE after the final slot. Otherwise it moves to ST_CLS_REQ.
- ST_CLS_REQ and ST_CLS_WAIT read the class word, then move to ST_HDR_REQ.
- ST_HDR_REQ and ST_HDR_WAIT read the header word and load the record, then move to ST_EMIT.
- ST_EMIT holds until the record is accepted. It then moves to ST_ID_REQ, or to ST_DONE when no slots remain.
- ST_DONE raises done and returns to ST_ID_REQ on start.

The slot counter advances as soon as the identity response arrives, before any record for that slot leaves.

Top module: `cfg_enum_scanner`

## Requirements
- R1: After reset, done, rd_req_valid and rec_valid are all 0.
- R2: A start pulse in idle or done captures bus_sel. It restarts the scan at device 0, function 0 with an identity read (offset 0x00), and every request carries the captured bus number.
- R3: Identity reads visit the slots with the function (0..FUNC_COUNT-1) inside the device (0..DEV_COUNT-1). Each slot is read exactly once per scan.
- R4: An identity word of 0xFFFFFFFF produces no record and no further reads for that slot.
- R5: For an occupied slot, the block reads offset 0x08 and then offset 0x0C of the same slot, and then emits exactly one record. In that record, device ID = id[31:16] and vendor ID = id[15:0]. Class = cls[31:24], subclass = cls[23:16], programming interface = cls[15:8] and revision = cls[7:0]. The record also carries the slot's bus, device and function.
- R6: rec_hdr_raw is bits 22:16 of the offset-0x0C word, so bit 23 is ignored. rec_hdr_kind is 0 for standard (raw 0), 1 for bridge to a configuration bus (raw 1), 2 for bridge to a card bus (raw 2), and 3 for unrecognised (any other raw value).
- R7: While rd_req_valid is high and rd_req_ready is low, the request and its fields stay unchanged. No new request is issued until the previous read has returned.
- R8: While rec_valid is high and rec_ready is low, every record field holds. No read is issued while a record is pending.
- R9: done rises after the last slot (device DEV_COUNT-1, function FUNC_COUNT-1) has been handled, and then stays high with no requests until start. A start pulse during a scan is ignored.
- R10: A start pulse while done is high runs a complete new scan on the newly captured bus number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (honoured in idle/done) |
| bus_sel | input | 8 | Bus number captured at start |
| done | output | 1 | Scan complete |
| rd_req_valid | output | 1 | Configuration read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_bus | output | 8 | Request bus number |
| rd_req_dev | output | 5 | Request device number |
| rd_req_func | output | 3 | Request function number |
| rd_req_offset | output | 8 | Request byte offset of the word |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 32 | Read response word |
| rec_valid | output | 1 | Record valid |
| rec_ready | input | 1 | Record accepted |
| rec_bus | output | 8 | Record bus number |
| rec_dev | output | 5 | Record device number |
| rec_func | output | 3 | Record function number |
| rec_vendor | output | 16 | Vendor ID |
| rec_device | output | 16 | Device ID |
| rec_class | output | 8 | Class code |
| rec_subclass | output | 8 | Subclass code |
| rec_progif | output | 8 | Programming interface byte |
| rec_revision | output | 8 | Revision ID |
| rec_hdr_kind | output | 2 | Decoded header kind |
| rec_hdr_raw | output | 7 | Header type with bit 7 removed |

## Verification
The bench builds the block with its default 32 devices and 8 functions. This means every scan covers the full 256-slot walk, including the device wrap at function 7 and the terminal slot 31.7 that ends the scan. Scans run over a randomly occupied bus, a fully empty bus and a fully occupied bus. Back-pressure on the request, response and record channels is randomised, which exercises the hold rules. The header bytes cycle through all four kinds, and some have bit 7 set.

// File: rtl/cfgscan_pkg.sv
package cfgscan_pkg;

    localparam int DEV_FIELD_W  = 5;
    localparam int FUNC_FIELD_W = 3;
    localparam int BUS_FIELD_W  = 8;
    localparam int OFS_W        = 8;
    localparam int WORD_W       = 32;

    localparam logic [OFS_W-1:0]  OFS_IDENT  = 8'h00;
    localparam logic [OFS_W-1:0]  OFS_CLASS  = 8'h08;
    localparam logic [OFS_W-1:0]  OFS_HEADER = 8'h0C;
    localparam logic [WORD_W-1:0] EMPTY_WORD = 32'hFFFF_FFFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID_REQ,
        ST_ID_WAIT,
        ST_CLS_REQ,
        ST_CLS_WAIT,
        ST_HDR_REQ,
        ST_HDR_WAIT,
        ST_EMIT,
        ST_DONE
    } scan_state_e;

    typedef enum logic [1:0] {
        HDR_STANDARD = 2'd0,
        HDR_CFG_BRIDGE = 2'd1,
        HDR_CARD_BRIDGE = 2'd2,
        HDR_UNKNOWN = 2'd3
    } hdr_kind_e;

    typedef struct packed {
        logic [BUS_FIELD_W-1:0]  bus;
        logic [DEV_FIELD_W-1:0]  dev;
        logic [FUNC_FIELD_W-1:0] func;
        logic [15:0]             vendor;
        logic [15:0]             device;
        logic [7:0]              cls;
        logic [7:0]              subcls;
        logic [7:0]              progif;
        logic [7:0]              rev;
        hdr_kind_e               kind;
        logic [6:0]              raw;
    } scan_rec_t;

endpackage

// File: rtl/cfgscan_slot_ctr.sv
module cfgscan_slot_ctr
    import cfgscan_pkg::*;
#(
    parameter int DEV_COUNT  = 32,
    parameter int FUNC_COUNT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    step,
    output logic [DEV_FIELD_W:0]    dev,
    output logic [FUNC_FIELD_W-1:0] func,
    output logic                    at_last,
    output logic                    past_end
);

    localparam logic [FUNC_FIELD_W-1:0] FUNC_LAST = FUNC_FIELD_W'(FUNC_COUNT - 1);
    localparam logic [DEV_FIELD_W:0]    DEV_LAST  = (DEV_FIELD_W+1)'(DEV_COUNT - 1);
    localparam logic [DEV_FIELD_W:0]    DEV_END   = (DEV_FIELD_W+1)'(DEV_COUNT);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            dev  <= '0;
            func <= '0;
        end else if (step && !past_end) begin
            if (func == FUNC_LAST) begin
                func <= '0;
                dev  <= dev + 1'b1;
            end else begin
                func <= func + 1'b1;
            end
        end
    end

    assign at_last  = (dev == DEV_LAST) && (func == FUNC_LAST);
    assign past_end = (dev == DEV_END);

    // R3
    func_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !past_end && func == FUNC_LAST) |=> (func == '0 && dev == $past(dev) + 1'b1));

    // R3
    dev_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev <= DEV_END);

endmodule

// File: rtl/cfgscan_hdr_decode.sv
module cfgscan_hdr_decode
    import cfgscan_pkg::*;
(
    input  logic [WORD_W-1:0] hdr_word,
    output hdr_kind_e         kind,
    output logic [6:0]        raw
);

    assign raw = hdr_word[22:16];

    always_comb begin
        unique case (raw)
            7'd0:    kind = HDR_STANDARD;
            7'd1:    kind = HDR_CFG_BRIDGE;
            7'd2:    kind = HDR_CARD_BRIDGE;
            default: kind = HDR_UNKNOWN;
        endcase
    end

endmodule

// File: rtl/cfgscan_rec_hold.sv
module cfgscan_rec_hold
    import cfgscan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  scan_rec_t din,
    input  logic      ready,
    output logic      valid,
    output scan_rec_t dout
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            dout <= din;
        end
    end

    // R8
    rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(dout)));

    // R8
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !valid);

endmodule

// File: rtl/cfg_enum_scanner.sv
module cfg_enum_scanner
    import cfgscan_pkg::*;
#(
    parameter int DEV_COUNT  = 32,
    parameter int FUNC_COUNT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  bus_sel,
    output logic        done,
    output logic        rd_req_valid,
    input  logic        rd_req_ready,
    output logic [7:0]  rd_req_bus,
    output logic [4:0]  rd_req_dev,
    output logic [2:0]  rd_req_func,
    output logic [7:0]  rd_req_offset,
    input  logic        rd_rsp_valid,
    input  logic [31:0] rd_rsp_data,
    output logic        rec_valid,
    input  logic        rec_ready,
    output logic [7:0]  rec_bus,
    output logic [4:0]  rec_dev,
    output logic [2:0]  rec_func,
    output logic [15:0] rec_vendor,
    output logic [15:0] rec_device,
    output logic [7:0]  rec_class,
    output logic [7:0]  rec_subclass,
    output logic [7:0]  rec_progif,
    output logic [7:0]  rec_revision,
    output logic [1:0]  rec_hdr_kind,
    output logic [6:0]  rec_hdr_raw
);

    scan_state_e state_q, state_d;

    logic [BUS_FIELD_W-1:0]  bus_q;
    logic [DEV_FIELD_W-1:0]  cur_dev_q;
    logic [FUNC_FIELD_W-1:0] cur_func_q;
    logic [WORD_W-1:0]       id_word_q;
    logic [WORD_W-1:0]       cls_word_q;

    logic [DEV_FIELD_W:0]    ctr_dev;
    logic [FUNC_FIELD_W-1:0] ctr_func;
    logic                    ctr_at_last;
    logic                    ctr_past_end;

    logic ctr_clear, ctr_step, take_start, cap_slot, cap_id, cap_cls, rec_load;
    logic id_empty, rec_taken;

    hdr_kind_e  dec_kind;
    logic [6:0] dec_raw;
    scan_rec_t  rec_next, rec_q;

    cfgscan_slot_ctr #(
        .DEV_COUNT (DEV_COUNT),
        .FUNC_COUNT(FUNC_COUNT)
    ) u_slot_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctr_clear),
        .step    (ctr_step),
        .dev     (ctr_dev),
        .func    (ctr_func),
        .at_last (ctr_at_last),
        .past_end(ctr_past_end)
    );

    cfgscan_hdr_decode u_hdr_decode (
        .hdr_word(rd_rsp_data),
        .kind    (dec_kind),
        .raw     (dec_raw)
    );

    cfgscan_rec_hold u_rec_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .load (rec_load),
        .din  (rec_next),
        .ready(rec_ready),
        .valid(rec_valid),
        .dout (rec_q)
    );

    assign id_empty  = (rd_rsp_data == EMPTY_WORD);
    assign rec_taken = rec_valid && rec_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_ID_REQ;
            ST_ID_REQ:   if (rd_req_ready) state_d = ST_ID_WAIT;
            ST_ID_WAIT: begin
                if (rd_rsp_valid) begin
                    if (!id_empty)        state_d = ST_CLS_REQ;
                    else if (ctr_at_last) state_d = ST_DONE;
                    else                  state_d = ST_ID_REQ;
                end
            end
            ST_CLS_REQ:  if (rd_req_ready) state_d = ST_CLS_WAIT;
            ST_CLS_WAIT: if (rd_rsp_valid) state_d = ST_HDR_REQ;
            ST_HDR_REQ:  if (rd_req_ready) state_d = ST_HDR_WAIT;
            ST_HDR_WAIT: if (rd_rsp_valid) state_d = ST_EMIT;
            ST_EMIT: begin
                if (rec_taken) state_d = ctr_past_end ? ST_DONE : ST_ID_REQ;
            end
            ST_DONE:     if (start) state_d = ST_ID_REQ;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs and strobes per state
    always_comb begin
        rd_req_valid  = 1'b0;
        rd_req_offset = OFS_IDENT;
        done          = 1'b0;
        take_start    = 1'b0;
        ctr_clear     = 1'b0;
        ctr_step      = 1'b0;
        cap_slot      = 1'b0;
        cap_id        = 1'b0;
        cap_cls       = 1'b0;
        rec_load      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                take_start = start;
                ctr_clear  = start;
            end
            ST_ID_REQ: begin
                rd_req_valid  = 1'b1;
                rd_req_offset = OFS_IDENT;
                cap_slot      = rd_req_ready;
            end
            ST_ID_WAIT: begin
                ctr_step = rd_rsp_valid;
                cap_id   = rd_rsp_valid;
            end
            ST_CLS_REQ: begin
                rd_req_valid  = 1'b1;
                rd_req_offset = OFS_CLASS;
            end
            ST_CLS_WAIT: cap_cls = rd_rsp_valid;
            ST_HDR_REQ: begin
                rd_req_valid  = 1'b1;
                rd_req_offset = OFS_HEADER;
            end
            ST_HDR_WAIT: rec_load = rd_rsp_valid;
            ST_EMIT: ;
            ST_DONE: begin
                done       = 1'b1;
                take_start = start;
                ctr_clear  = start;
            end
            default: ;
        endcase
    end

    // Datapath captures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else if (take_start) begin
            bus_q <= bus_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (cap_slot) begin
            cur_dev_q  <= ctr_dev[DEV_FIELD_W-1:0];
            cur_func_q <= ctr_func;
        end
        if (cap_id)  id_word_q  <= rd_rsp_data;
        if (cap_cls) cls_word_q <= rd_rsp_data;
    end

    assign rd_req_bus  = bus_q;
    assign rd_req_dev  = (state_q == ST_ID_REQ) ? ctr_dev[DEV_FIELD_W-1:0] : cur_dev_q;
    assign rd_req_func = (state_q == ST_ID_REQ) ? ctr_func : cur_func_q;

    always_comb begin
        rec_next.bus    = bus_q;
        rec_next.dev    = cur_dev_q;
        rec_next.func   = cur_func_q;
        rec_next.vendor = id_word_q[15:0];
        rec_next.device = id_word_q[31:16];
        rec_next.cls    = cls_word_q[31:24];
        rec_next.subcls = cls_word_q[23:16];
        rec_next.progif = cls_word_q[15:8];
        rec_next.rev    = cls_word_q[7:0];
        rec_next.kind   = dec_kind;
        rec_next.raw    = dec_raw;
    end

    assign rec_bus      = rec_q.bus;
    assign rec_dev      = rec_q.dev;
    assign rec_func     = rec_q.func;
    assign rec_vendor   = rec_q.vendor;
    assign rec_device   = rec_q.device;
    assign rec_class    = rec_q.cls;
    assign rec_subclass = rec_q.subcls;
    assign rec_progif   = rec_q.progif;
    assign rec_revision = rec_q.rev;
    assign rec_hdr_kind = rec_q.kind;
    assign rec_hdr_raw  = rec_q.raw;

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_offset)
            && $stable(rd_req_dev) && $stable(rd_req_func) && $stable(rd_req_bus)));

    // R8
    scan_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> !rd_req_valid);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_req_valid && !rec_valid));

    // R4
    empty_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ID_WAIT && rd_rsp_valid && id_empty) |=> (!rec_valid && rd_req_offset == OFS_IDENT));

endmodule

// File: tb/tb_cfg_enum_scanner.sv
module tb_cfg_enum_scanner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  bus_sel = '0;
    logic        done;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [7:0]  rd_req_bus;
    logic [4:0]  rd_req_dev;
    logic [2:0]  rd_req_func;
    logic [7:0]  rd_req_offset;
    logic        rd_rsp_valid = 1'b0;
    logic [31:0] rd_rsp_data = '0;
    logic        rec_valid;
    logic        rec_ready = 1'b0;
    logic [7:0]  rec_bus;
    logic [4:0]  rec_dev;
    logic [2:0]  rec_func;
    logic [15:0] rec_vendor, rec_device;
    logic [7:0]  rec_class, rec_subclass, rec_progif, rec_revision;
    logic [1:0]  rec_hdr_kind;
    logic [6:0]  rec_hdr_raw;

    cfg_enum_scanner dut (.*);

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int mode = 0;
    int unsigned salt = 0;
    logic [7:0] exp_bus = '0;
    int exp_dev = 0, exp_func = 0, exp_phase = 0;
    int rec_ptr = 0, rec_count = 0;
    int kind_seen[4];
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int unsigned mix(input int d, input int f);
        int unsigned h;
        h = (int'(exp_bus) * 131 + d * 29 + f * 7 + salt) * 32'h9E3779B1;
        return h ^ (h >> 13);
    endfunction

    function automatic bit present(input int d, input int f);
        if (mode == 1) return 1'b0;
        if (mode == 2) return 1'b1;
        if ((d == 0 && f == 0) || (d == 31 && f == 7)) return 1'b1;
        return (mix(d, f) % 3) != 0;
    endfunction

    function automatic logic [31:0] id_word(input int d, input int f);
        int unsigned h = mix(d, f);
        return {h[31:16], 1'b0, h[14:0]};
    endfunction

    function automatic logic [31:0] cls_word(input int d, input int f);
        return mix(d, f) * 3 + 32'h1234_5678;
    endfunction

    function automatic logic [6:0] hdr_raw(input int d, input int f);
        int unsigned s = mix(d, f) % 5;
        case (s)
            0: return 7'd0;
            1: return 7'd1;
            2: return 7'd2;
            3: return 7'd5;
            default: return 7'h7F;
        endcase
    endfunction

    function automatic logic [31:0] hdr_word(input int d, input int f);
        int unsigned h = mix(d, f);
        return {h[31:24], h[4], hdr_raw(d, f), h[15:0]};
    endfunction

    function automatic logic [1:0] hdr_kind(input logic [6:0] r);
        return (r <= 7'd2) ? r[1:0] : 2'd3;
    endfunction

    // Configuration-space responder: checks request order (R2, R3, R5), answers words
    initial begin
        bit have_rsp = 0;
        int lat = 0;
        logic [31:0] word = '0;
        bit stalled = 0;
        logic [23:0] held = '0;
        forever begin
            @(negedge clk);
            rd_rsp_valid = 1'b0;
            if (have_rsp) begin
                if (lat == 0) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = word;
                    have_rsp     = 0;
                end else lat--;
            end
            if (stalled) begin
                chk(rd_req_valid && {rd_req_bus, rd_req_dev, rd_req_func, rd_req_offset} == held,
                    "R7 request held", {rd_req_valid, rd_req_bus, rd_req_dev, rd_req_func, rd_req_offset},
                    {1'b1, held});
            end
            if (rd_req_valid && (have_rsp || rd_rsp_valid))
                chk(0, "R7 second request outstanding", 1, 0);
            rd_req_ready = ($urandom % 4) != 0;
            stalled = rd_req_valid && !rd_req_ready;
            held = {rd_req_bus, rd_req_dev, rd_req_func, rd_req_offset};
            if (rd_req_valid && rd_req_ready && rst_n) begin
                logic [7:0] eo;
                eo = (exp_phase == 0) ? 8'h00 : (exp_phase == 1) ? 8'h08 : 8'h0C;
                chk({rd_req_bus, rd_req_dev, rd_req_func, rd_req_offset} ==
                    {exp_bus, 5'(exp_dev), 3'(exp_func), eo},
                    (exp_phase == 0) ? "R2/R3 identity read slot" : "R5 follow-up read slot",
                    {rd_req_bus, rd_req_dev, rd_req_func, rd_req_offset},
                    {exp_bus, 5'(exp_dev), 3'(exp_func), eo});
                if (exp_phase == 0) word = present(exp_dev, exp_func) ? id_word(exp_dev, exp_func) : 32'hFFFF_FFFF;
                else if (exp_phase == 1) word = cls_word(exp_dev, exp_func);
                else word = hdr_word(exp_dev, exp_func);
                if ((exp_phase == 0 && !present(exp_dev, exp_func)) || exp_phase == 2) begin
                    exp_phase = 0;
                    exp_func++;
                    if (exp_func == 8) begin exp_func = 0; exp_dev++; end
                end else exp_phase++;
                have_rsp = 1;
                lat = $urandom % 3;
            end
        end
    end

    // Record consumer: checks R4, R5, R6, R8
    initial begin
        bit stalled = 0;
        logic [127:0] held = '0;
        forever begin
            @(negedge clk);
            if (stalled)
                chk(rec_valid && {rec_bus, rec_dev, rec_func, rec_vendor, rec_device, rec_class, rec_subclass,
                    rec_progif, rec_revision, rec_hdr_kind, rec_hdr_raw} == held[106:0],
                    "R8 record held", rec_valid, 1);
            if (rec_valid && rd_req_valid) chk(0, "R8 read while record pending", 1, 0);
            rec_ready = ($urandom % 3) != 0;
            stalled = rec_valid && !rec_ready;
            held = 128'({rec_bus, rec_dev, rec_func, rec_vendor, rec_device, rec_class, rec_subclass,
                    rec_progif, rec_revision, rec_hdr_kind, rec_hdr_raw});
            if (rec_valid && rec_ready && rst_n) begin
                int d, f;
                while (rec_ptr < 256 && !present(rec_ptr / 8, rec_ptr % 8)) rec_ptr++;
                d = rec_ptr / 8;
                f = rec_ptr % 8;
                chk({rec_bus, rec_dev, rec_func} == {exp_bus, 5'(d), 3'(f)}, "R4 record slot (empty skipped)",
                    {rec_bus, rec_dev, rec_func}, {exp_bus, 5'(d), 3'(f)});
                chk({rec_device, rec_vendor} == id_word(d, f), "R5 identity fields",
                    {rec_device, rec_vendor}, id_word(d, f));
                chk({rec_class, rec_subclass, rec_progif, rec_revision} == cls_word(d, f), "R5 class fields",
                    {rec_class, rec_subclass, rec_progif, rec_revision}, cls_word(d, f));
                chk(rec_hdr_raw == hdr_raw(d, f) && rec_hdr_kind == hdr_kind(hdr_raw(d, f)), "R6 header decode",
                    {rec_hdr_kind, rec_hdr_raw}, {hdr_kind(hdr_raw(d, f)), hdr_raw(d, f)});
                kind_seen[rec_hdr_kind]++;
                rec_ptr++;
                rec_count++;
            end
        end
    end

    task automatic run_scan(input int m, input logic [7:0] bus, input bit poke_start);
        int expected_recs = 0;
        int n = 0;
        mode = m;
        salt = $urandom;
        exp_bus = bus;
        exp_dev = 0; exp_func = 0; exp_phase = 0;
        rec_ptr = 0; rec_count = 0;
        for (int d = 0; d < 32; d++)
            for (int f = 0; f < 8; f++)
                if (present(d, f)) expected_recs++;
        @(negedge clk);
        bus_sel = bus;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bus_sel = ~bus;
        while (!done && n < 30000) begin
            @(negedge clk);
            n++;
            if (poke_start && n == 500) start = 1'b1;   // R9: ignored mid-scan
            else start = 1'b0;
        end
        chk(done, "R9 done reached", done, 1);
        chk(exp_dev == 32 && exp_func == 0, "R3 all slots read once", exp_dev * 8 + exp_func, 256);
        chk(rec_count == expected_recs, "R5 record count", rec_count, expected_recs);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(done && !rd_req_valid && !rec_valid, "R9 done holds idle", {done, rd_req_valid, rec_valid}, 3'b100);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!done && !rd_req_valid && !rec_valid, "R1 reset state", {done, rd_req_valid, rec_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !rd_req_valid && !rec_valid, "R1 idle after reset", {done, rd_req_valid, rec_valid}, 0);
        run_scan(0, 8'h3C, 1'b1);
        chk(kind_seen[0] > 0 && kind_seen[1] > 0 && kind_seen[2] > 0 && kind_seen[3] > 0, "R6 all kinds seen",
            {kind_seen[0][7:0], kind_seen[1][7:0], kind_seen[2][7:0], kind_seen[3][7:0]}, 1);
        run_scan(1, 8'hA5, 1'b0);   // R4: empty bus, no records
        chk(rec_count == 0, "R4 empty bus emits nothing", rec_count, 0);
        run_scan(2, 8'h01, 1'b0);   // R10: restart from done, full bus
        run_scan(0, 8'hFF, 1'b1);   // R10: restart on new bus
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule